// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register memory transfer into a stream of single-word memory requests. It receives a register selection mask, a base address and the addressing options (count upward or downward, step before or after each access, write the base back or not, load or store, user-bank access). It then presents one request per selected register, always in ascending register index. Each request carries the register index and the word address. A request/acknowledge handshake on the memory side holds the sequence until the access is accepted.

When every request has been accepted, the block raises a one-cycle completion pulse. With it come the value to write back into the base register, a flag saying whether that writeback may happen, a cycle estimate and a flag telling the core that the program counter was reloaded. Two compact stack forms are also accepted. The push form uses an 8-bit mask plus a bit for the link register. The pop form uses an 8-bit mask plus a bit for the program counter. Both use the stack pointer as base and always write it back.

Top module: `lsm_seq`

## Requirements
- R1: After `start` is taken in the idle state, exactly one request is issued per set bit of the effective mask, in strictly ascending register index, with `req_write` = 1 for stores and 0 for loads.
- R2: Consecutive requests of one transfer use word addresses 4 apart, the lowest register at the lowest address.
- R3: While `req_valid` is 1 and `req_ack` is 0, the request fields stay unchanged on the next cycle.
- R4: With `up`=1, the first address is base+4 when `pre`=1 and base when `pre`=0.
- R5: With `up`=0, the lowest address is base−4·n (`pre`=1) or base−4·n+4 (`pre`=0), n being the mask population; the writeback value is base−4·n.
- R6: With `up`=1, the writeback value is base+4·n; `wb_valid` is 0 whenever `wb_en`=0 in the block form.
- R7: Register 15 is always the last request, and on a load `pc_loaded` is 1 in the completion cycle.
- R8: On a load whose mask includes `base_idx`, `wb_valid` is 1 only if the base is the only set bit or some higher-index bit is also set. Stores write back regardless.
- R9: `req_user` is 1 when `user_sel`=1, except for a load whose mask has bit 15 set. In the stack forms it is 0.
- R10: Push form (`form`=1): mask is list[7:0] plus register 14 when list[8]=1, addresses run upward from SP−4·n, store, writeback SP−4·n.
- R11: Pop form (`form`=2): mask is list[7:0] plus register 15 when list[8]=1, addresses run upward from SP, load, writeback SP+4·n.
- R12: In the completion cycle `cycle_cnt` = 2 + n, plus 2 when the program counter is loaded.
- R13: `done` is a single-cycle pulse, and a `start` seen while a transfer runs has no effect on it.
- R14: An empty mask produces no request; `done` follows two cycles after `start` with writeback value equal to the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| form | input | 2 | 0 block form, 1 push, 2 pop |
| list | input | 16 | Register selection mask |
| base_addr | input | 32 | Base register value (stack pointer in stack forms) |
| base_idx | input | 4 | Index of the base register (block form) |
| up | input | 1 | 1 count upward, 0 downward |
| pre | input | 1 | 1 step before access, 0 after |
| wb_en | input | 1 | Base writeback requested (block form) |
| load | input | 1 | 1 load, 0 store (block form) |
| user_sel | input | 1 | User-bank access requested (block form) |
| req_valid | output | 1 | Memory request present |
| req_ack | input | 1 | Memory accepts the current request |
| req_idx | output | 4 | Register index of the request |
| req_addr | output | 32 | Word address of the request |
| req_write | output | 1 | Request is a store |
| req_user | output | 1 | Request targets the user register bank |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | Base writeback allowed (with done) |
| wb_value | output | 32 | Base writeback value (with done) |
| cycle_cnt | output | 6 | Cycle estimate (with done) |
| pc_loaded | output | 1 | Program counter reloaded (with done) |

## Verification
All four stepping modes run on masks of different shape. A sparse mask shows a skipped register, a contiguous middle mask shows the downward offset, and the full mask reaches the program counter. Acknowledge patterns of every cycle, every second cycle and every third cycle separate correct stalling from a sequencer that advances on its own. Loads with the base highest, not highest and alone in the mask, against a store with the base highest, separate the writeback rule from a simple mask test. The push, pop and empty-mask cases each expose their own remap or termination path.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
   typedef enum logic [1:0] {
      XF_BLOCK = 2'd0,
      XF_PUSH  = 2'd1,
      XF_POP   = 2'd2
   } xf_form_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode import lsm_pkg::*; #(
   parameter int LIST_W  = 16,
   parameter int STACK_W = 8,
   parameter int IDX_W   = 4,
   parameter int SP_IDX  = 13
)(
   input  logic [1:0]        form,
   input  logic [LIST_W-1:0] list,
   input  logic [IDX_W-1:0]  base_idx,
   input  logic              up,
   input  logic              pre,
   input  logic              wb_en,
   input  logic              load,
   input  logic              user_sel,
   output logic [LIST_W-1:0] mask,
   output logic              eff_up,
   output logic              eff_pre,
   output logic              eff_wb,
   output logic              eff_load,
   output logic              eff_user,
   output logic [IDX_W-1:0]  eff_bidx
);
   localparam int LINK_IDX = LIST_W - 2;
   localparam int PC_IDX   = LIST_W - 1;

   logic [LIST_W-1:0] low_part;

   assign low_part = LIST_W'(list[STACK_W-1:0]);

   always_comb begin
      mask     = list;
      eff_up   = up;
      eff_wb   = wb_en;
      eff_load = load;
      eff_user = user_sel & (~load | ~list[PC_IDX]);
      eff_bidx = base_idx;
      eff_pre  = up ? pre : ~pre;
      case (xf_form_e'(form))
         XF_PUSH: begin
            mask           = low_part;
            mask[LINK_IDX] = list[STACK_W];
            eff_up   = 1'b0;
            eff_pre  = 1'b0;
            eff_wb   = 1'b1;
            eff_load = 1'b0;
            eff_user = 1'b0;
            eff_bidx = IDX_W'(SP_IDX);
         end
         XF_POP: begin
            mask         = low_part;
            mask[PC_IDX] = list[STACK_W];
            eff_up   = 1'b1;
            eff_pre  = 1'b0;
            eff_wb   = 1'b1;
            eff_load = 1'b1;
            eff_user = 1'b0;
            eff_bidx = IDX_W'(SP_IDX);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/lsm_popcnt.sv
module lsm_popcnt #(
   parameter int W  = 16,
   parameter int CW = 6
)(
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] count
);
   always_comb begin
      count = '0;
      for (int i = 0; i < W; i++) count = count + CW'(vec[i]);
   end
endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
   parameter int W     = 16,
   parameter int IDX_W = 4
)(
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq import lsm_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int LIST_W     = 16,
   parameter int STACK_W    = 8,
   parameter int CNT_W      = 6,
   parameter int WORD_BYTES = 4,
   parameter int SP_IDX     = 13,
   parameter int BASE_RULE  = 1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [1:0]                form,
   input  logic [LIST_W-1:0]         list,
   input  logic [ADDR_W-1:0]         base_addr,
   input  logic [$clog2(LIST_W)-1:0] base_idx,
   input  logic                      up,
   input  logic                      pre,
   input  logic                      wb_en,
   input  logic                      load,
   input  logic                      user_sel,
   output logic                      req_valid,
   input  logic                      req_ack,
   output logic [$clog2(LIST_W)-1:0] req_idx,
   output logic [ADDR_W-1:0]         req_addr,
   output logic                      req_write,
   output logic                      req_user,
   output logic                      done,
   output logic                      wb_valid,
   output logic [ADDR_W-1:0]         wb_value,
   output logic [CNT_W-1:0]          cycle_cnt,
   output logic                      pc_loaded
);
   localparam int IDX_W  = $clog2(LIST_W);
   localparam int PC_IDX = LIST_W - 1;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
   localparam logic [CNT_W-1:0]  BASE_CYC = CNT_W'(2);
   localparam logic [CNT_W-1:0]  PC_CYC   = CNT_W'(2);

   if (LIST_W != (1 << IDX_W)) begin : g_bad_list
      $error("LIST_W must be a power of two");
   end
   if (LIST_W < STACK_W + 2) begin : g_bad_stack
      $error("LIST_W too small for stack form");
   end
   if ((1 << CNT_W) <= LIST_W + 4) begin : g_bad_cnt
      $error("CNT_W too small for cycle count");
   end
   if (SP_IDX >= LIST_W - 2) begin : g_bad_sp
      $error("SP_IDX collides with link or PC");
   end

   logic [LIST_W-1:0] d_mask;
   logic              d_up, d_pre, d_wb, d_load, d_user;
   logic [IDX_W-1:0]  d_bidx;
   logic [CNT_W-1:0]  d_cnt;

   lsm_decode #(.LIST_W(LIST_W), .STACK_W(STACK_W), .IDX_W(IDX_W), .SP_IDX(SP_IDX)) dec_i (
      .form(form), .list(list), .base_idx(base_idx), .up(up), .pre(pre),
      .wb_en(wb_en), .load(load), .user_sel(user_sel), .mask(d_mask),
      .eff_up(d_up), .eff_pre(d_pre), .eff_wb(d_wb), .eff_load(d_load),
      .eff_user(d_user), .eff_bidx(d_bidx)
   );

   lsm_popcnt #(.W(LIST_W), .CW(CNT_W)) cnt_i (.vec(d_mask), .count(d_cnt));

   seq_state_e        state;
   logic [LIST_W-1:0] pend, full;
   logic [ADDR_W-1:0] cur, low_a;
   logic [CNT_W-1:0]  n_r;
   logic              up_r, pre_r, wb_r, ld_r, us_r;
   logic [IDX_W-1:0]  bidx_r;
   logic [IDX_W-1:0]  p_idx;
   logic              p_any;
   logic [ADDR_W-1:0] span, first_a;

   lsm_lowbit #(.W(LIST_W), .IDX_W(IDX_W)) pick_i (.vec(pend), .idx(p_idx), .any(p_any));

   assign span    = ADDR_W'(d_cnt) * STEP;
   assign first_a = d_up ? base_addr : base_addr - span;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pend   <= '0;
         full   <= '0;
         cur    <= '0;
         low_a  <= '0;
         n_r    <= '0;
         up_r   <= 1'b0;
         pre_r  <= 1'b0;
         wb_r   <= 1'b0;
         ld_r   <= 1'b0;
         us_r   <= 1'b0;
         bidx_r <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               pend   <= d_mask;
               full   <= d_mask;
               n_r    <= d_cnt;
               cur    <= first_a;
               low_a  <= first_a;
               up_r   <= d_up;
               pre_r  <= d_pre;
               wb_r   <= d_wb;
               ld_r   <= d_load;
               us_r   <= d_user;
               bidx_r <= d_bidx;
               state  <= ST_RUN;
            end
            ST_RUN: begin
               if (!p_any) state <= ST_FIN;
               else if (req_ack) begin
                  pend[p_idx] <= 1'b0;
                  cur         <= cur + STEP;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // writeback permission when the base register is part of a load
   logic base_in, wb_ok;
   assign base_in = full[bidx_r];

   if (BASE_RULE != 0) begin : g_rule_keep
      logic sole, above;
      assign sole  = (full == (LIST_W'(1) << bidx_r));
      assign above = |((full >> bidx_r) >> 1);
      assign wb_ok = ~(ld_r & base_in) | sole | above;
   end else begin : g_rule_drop
      assign wb_ok = ~(ld_r & base_in);
   end

   logic pc_hit;
   assign pc_hit = ld_r & full[PC_IDX];

   assign req_valid = (state == ST_RUN) && p_any;
   assign req_idx   = p_idx;
   assign req_addr  = cur + (pre_r ? STEP : '0);
   assign req_write = ~ld_r;
   assign req_user  = us_r;
   assign done      = (state == ST_FIN);
   assign wb_valid  = done & wb_r & wb_ok;
   assign wb_value  = done ? (up_r ? cur : low_a) : '0;
   assign cycle_cnt = done ? (BASE_CYC + n_r + (pc_hit ? PC_CYC : '0)) : '0;
   assign pc_loaded = done & pc_hit;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int LIST_W = 16,
   parameter int IDX_W  = 4,
   parameter int WORD_BYTES = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ack,
   input logic [IDX_W-1:0]  req_idx,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_write,
   input logic              done
);
   // R1
   idx_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack |=> !req_valid || (req_idx > $past(req_idx)));

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack |=> !req_valid || (req_addr == $past(req_addr) + ADDR_W'(WORD_BYTES)));

   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ack |=> req_valid && $stable(req_idx) && $stable(req_addr) && $stable(req_write));

   // R7
   pc_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ack && (req_idx == IDX_W'(LIST_W - 1)) |=> !req_valid);

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R13
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_valid);
endmodule

bind lsm_seq lsm_seq_chk #(.ADDR_W(ADDR_W), .LIST_W(LIST_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
   .req_idx(req_idx), .req_addr(req_addr), .req_write(req_write), .done(done)
);

// File: tb/lsm_seq_tb_top.sv
`timescale 1ns/1ps
module lsm_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  form = 2'd0;
   logic [15:0] list = '0;
   logic [31:0] base_addr = '0;
   logic [3:0]  base_idx = '0;
   logic        up = 1'b0, pre = 1'b0, wb_en = 1'b0, load = 1'b0, user_sel = 1'b0;
   logic        req_ack = 1'b0;
   logic        req_valid, req_write, req_user, done, wb_valid, pc_loaded;
   logic [3:0]  req_idx;
   logic [31:0] req_addr, wb_value;
   logic [5:0]  cycle_cnt;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   lsm_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .form(form), .list(list),
      .base_addr(base_addr), .base_idx(base_idx), .up(up), .pre(pre),
      .wb_en(wb_en), .load(load), .user_sel(user_sel), .req_valid(req_valid),
      .req_ack(req_ack), .req_idx(req_idx), .req_addr(req_addr),
      .req_write(req_write), .req_user(req_user), .done(done),
      .wb_valid(wb_valid), .wb_value(wb_value), .cycle_cnt(cycle_cnt),
      .pc_loaded(pc_loaded)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input int f, input logic [15:0] lst, input logic [31:0] b,
                         input int bidx, input bit u, input bit p, input bit w,
                         input bit ld, input bit us, input int ackpat, input bit poke,
                         input string req);
      logic [15:0] m;
      bit fup, fpre, fwb, fld, fus, ok;
      int fb, n, k, stage, cyc;
      int q_idx[$];
      logic [31:0] q_addr[$];
      logic [31:0] exp_wb;
      bit exp_wbv, exp_pcl;
      int exp_cyc;
      m = lst; fup = u; fpre = p; fwb = w; fld = ld; fb = bidx;
      fus = us && (!ld || !lst[15]);
      if (f == 1) begin
         m = {7'd0, lst[8], 6'd0, lst[7:0]};
         m[15] = 1'b0;
         m = 16'(lst[7:0]) | (16'(lst[8]) << 14);
         fup = 0; fpre = 1; fwb = 1; fld = 0; fus = 0; fb = 13;
      end else if (f == 2) begin
         m = 16'(lst[7:0]) | (16'(lst[8]) << 15);
         fup = 1; fpre = 0; fwb = 1; fld = 1; fus = 0; fb = 13;
      end
      n = $countones(m);
      k = 0;
      for (int i = 0; i < 16; i++) begin
         if (m[i]) begin
            q_idx.push_back(i);
            if (fup) q_addr.push_back(b + 32'(4 * k) + (fpre ? 32'd4 : 32'd0));
            else     q_addr.push_back(b - 32'(4 * n) + 32'(4 * k) + (fpre ? 32'd0 : 32'd4));
            k++;
         end
      end
      exp_wb = fup ? b + 32'(4 * n) : b - 32'(4 * n);
      ok = 1'b1;
      if (fld && m[fb]) ok = (m == (16'd1 << fb)) || ((m >> (fb + 1)) != 0);
      exp_wbv = fwb && ok;
      exp_pcl = fld && m[15];
      exp_cyc = 2 + n + (exp_pcl ? 2 : 0);

      @(negedge clk);
      form = 2'(f); list = lst; base_addr = b; base_idx = 4'(bidx);
      up = u; pre = p; wb_en = w; load = ld; user_sel = us; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      stage = 0;
      cyc = 0;
      while (cyc < 200) begin
         req_ack = 1'b0;
         if (poke && cyc == 1) begin start = 1'b1; list = 16'hFFFF; end
         else if (poke && cyc == 2) start = 1'b0;
         if (q_idx.size() > 0) begin
            chk(req_valid == 1'b1, req, "req_valid", req_valid, 1);
            chk(req_idx == 4'(q_idx[0]), req, "req_idx", req_idx, q_idx[0]);
            chk(req_addr == q_addr[0], req, "req_addr", req_addr, q_addr[0]);
            chk(req_write == !fld, req, "req_write", req_write, !fld);
            chk(req_user == fus, req, "req_user", req_user, fus);
            chk(done == 1'b0, req, "early done", done, 0);
            if (ackpat == 0 || (ackpat == 1 && cyc % 2 == 1) || (ackpat == 2 && cyc % 3 == 2)) begin
               req_ack = 1'b1;
               void'(q_idx.pop_front());
               void'(q_addr.pop_front());
            end
         end else if (stage == 0) begin
            chk(req_valid == 1'b0 && done == 1'b0, req, "gap cycle", {req_valid, done}, 0);
            stage = 1;
         end else begin
            chk(done == 1'b1, req, "done", done, 1);
            chk(wb_valid == exp_wbv, req, "wb_valid", wb_valid, exp_wbv);
            chk(wb_value == exp_wb, req, "wb_value", wb_value, exp_wb);
            chk(int'(cycle_cnt) == exp_cyc, req, "cycle_cnt", cycle_cnt, exp_cyc);
            chk(pc_loaded == exp_pcl, req, "pc_loaded", pc_loaded, exp_pcl);
            break;
         end
         cyc++;
         @(negedge clk);
      end
      req_ack = 1'b0;
      @(negedge clk);
      // R13 single-cycle completion
      chk(done == 1'b0 && req_valid == 1'b0, "R13", "after done", {done, req_valid}, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_valid == 1'b0 && done == 1'b0, "R13", "reset state", {req_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_valid == 1'b0 && done == 1'b0, "R1", "idle before start", {req_valid, done}, 0);
      // R1 R4 R6: upward, step after, sparse load
      run_op(0, 16'h001A, 32'h0000_1000, 0, 1, 0, 1, 1, 0, 0, 0, "R4");
      // R3 R4: upward, step before, store with stalls
      run_op(0, 16'h0C05, 32'h0000_1100, 2, 1, 1, 1, 0, 0, 1, 0, "R3");
      // R5: downward, step before, store
      run_op(0, 16'h00F0, 32'h0000_2000, 1, 0, 1, 1, 0, 0, 2, 0, "R5");
      // R5 R7 R12: downward, step after, load with PC
      run_op(0, 16'h8003, 32'h0000_2100, 5, 0, 0, 1, 1, 0, 0, 0, "R7");
      // R6: no writeback requested
      run_op(0, 16'h0300, 32'h0000_2200, 1, 1, 0, 0, 1, 0, 0, 0, "R6");
      // R8: base highest in load mask, writeback suppressed
      run_op(0, 16'h0014, 32'h0000_3000, 4, 1, 0, 1, 1, 0, 0, 0, "R8");
      // R8: base not highest, writeback kept
      run_op(0, 16'h0050, 32'h0000_3100, 4, 1, 0, 1, 1, 0, 1, 0, "R8");
      // R8: base sole member
      run_op(0, 16'h0010, 32'h0000_3200, 4, 0, 1, 1, 1, 0, 0, 0, "R8");
      // R8: store with base highest still writes back
      run_op(0, 16'h0014, 32'h0000_3300, 4, 1, 0, 1, 0, 0, 0, 0, "R8");
      // R9: user bank store, user load without PC, user load with PC
      run_op(0, 16'h0006, 32'h0000_4000, 0, 1, 0, 0, 0, 1, 0, 0, "R9");
      run_op(0, 16'h0006, 32'h0000_4100, 0, 1, 0, 0, 1, 1, 0, 0, "R9");
      run_op(0, 16'h8006, 32'h0000_4200, 0, 1, 0, 0, 1, 1, 2, 0, "R9");
      // R10: push with link register
      run_op(1, 16'h0103, 32'h0000_3000, 0, 1, 1, 0, 1, 1, 1, 0, "R10");
      // R11: pop with program counter
      run_op(2, 16'h0181, 32'h0000_3000, 0, 0, 1, 0, 0, 1, 0, 0, "R11");
      // R14: empty mask
      run_op(0, 16'h0000, 32'h0000_5000, 0, 1, 1, 1, 1, 0, 0, 0, "R14");
      // R13: start while busy is ignored
      run_op(0, 16'h0222, 32'h0000_6000, 0, 1, 0, 1, 0, 0, 2, 1, "R13");
      // R12 R2: full mask, upward step before
      run_op(0, 16'hFFFF, 32'h0000_7000, 3, 1, 1, 1, 1, 0, 0, 0, "R12");
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule